// File: doc/BRIEF.md
# Port-Denied Load Replay Queue

This block parks load operations whose data-cache read was refused because every read port was already taken in that cycle, and hands them back to the execute stage on later cycles. Each parked load is stored with its tag and an opaque payload that stands for its already-translated request. Replaying that payload means the load never goes back through address translation.

On every cycle the block works out how many parked loads may be re-issued. Other deferred memory operations have already taken part of the issue width, and replays fill the remaining slots before any normal instruction selection. Up to `NPOP` of the oldest entries are presented on the replay outputs and are removed at the next clock edge. The block also keeps one "delayed" flag per load tag. The load queue uses these flags to leave waiting loads out of its memory-order violation scan. Forwarding or rescheduling logic clears a flag through a separate input. A flush discards every parked load and every flag. `DEPTH` must be a power of two.

Top module: `load_replay_queue`

## Requirements
- R1: A defer request that is not a flush cycle and finds fewer than DEPTH entries is appended behind all entries already held.
- R2: Replays leave in arrival order: slot 0 of replay_tag carries the oldest held entry and slot i the next ones in turn, and replay_valid is always a low-aligned run of ones.
- R3: The number of replays in a cycle equals min(NPOP, occupancy, issue_width - other_used), where the last term is zero when other_used is at least issue_width. The entries replayed are gone at the next clock edge.
- R4: Whenever at least one replay is presented, the replay count plus other_used does not exceed issue_width.
- R5: activity is high exactly when the queue holds at least one entry or other_used is non-zero.
- R6: While flush is high, no replay is presented and any defer request is dropped. From the next cycle on, the queue is empty and every delayed flag is zero.
- R7: Bit t of delayed_vec goes high in the cycle after a defer of tag t is accepted. It goes low in the cycle after clr_valid with clr_tag t. If the same tag is both cleared and accepted in one cycle, the set wins.
- R8: violation_vec equals scan_vec with every bit whose delayed flag is high forced to zero.
- R9: overflow is high in any cycle where defer_valid is high while the queue holds DEPTH entries. That request is dropped even if a replay frees an entry in the same cycle.
- R10: A defer accepted in the same cycle as one replay leaves the occupancy unchanged; both actions take effect.
- R11: Each replayed entry's payload is returned bit-exact, together with the tag it was stored with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all parked loads and flags |
| defer_valid | input | 1 | A load was refused a read port this cycle |
| defer_tag | input | TAG_W | Tag of the refused load |
| defer_payload | input | PAY_W | Saved translated request of the refused load |
| issue_width | input | BUD_W | Total issue slots this cycle |
| other_used | input | BUD_W | Slots already taken by other deferred memory ops |
| clr_valid | input | 1 | Clear a delayed flag (forwarded or rescheduled load) |
| clr_tag | input | TAG_W | Tag whose delayed flag is cleared |
| scan_vec | input | 2**TAG_W | Raw violation candidates from the load queue scan |
| replay_valid | output | NPOP | Replay slot valid, low-aligned |
| replay_tag | output | NPOP*TAG_W | Replayed tags, slot 0 oldest |
| replay_payload | output | NPOP*PAY_W | Replayed payloads, aligned with the tags |
| activity | output | 1 | Queue non-empty or other deferred issue this cycle |
| overflow | output | 1 | Defer request refused because the queue is full |
| delayed_vec | output | 2**TAG_W | Per-tag delayed flag |
| violation_vec | output | 2**TAG_W | Scan candidates with delayed loads removed |

## Verification
The budget is tested with other_used below, equal to and above issue_width, so a correct min() can be told apart from a wrapped subtraction. It is also tested with issue_width wider than NPOP and with a queue shallower than the budget. The queue is filled to exactly DEPTH, and a defer plus one replay is applied at DEPTH-1, which shows whether the simultaneous push and pop keeps the count; the later overflow lands on precisely the right request. Flag tests clear an idle tag, clear a set tag, and clear and set the same tag together. A long random phase with occasional flushes then compares every output on every cycle against a queue-based model.

// File: rtl/rlq_pkg.sv
package rlq_pkg;
    parameter int unsigned RLQ_DEPTH = 16;
    parameter int unsigned RLQ_TAG_W = 4;
    parameter int unsigned RLQ_PAY_W = 16;
    parameter int unsigned RLQ_BUD_W = 4;
    parameter int unsigned RLQ_NPOP  = 2;
endpackage

// File: rtl/rlq_store.sv
module rlq_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned TAG_W = 4,
    parameter int unsigned PAY_W = 16,
    parameter int unsigned NPOP  = 2,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1),
    parameter int unsigned POPW  = $clog2(NPOP + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    push,
    input  logic [TAG_W-1:0]        push_tag,
    input  logic [PAY_W-1:0]        push_pay,
    input  logic [POPW-1:0]         pop_n,
    output logic [CNT_W-1:0]        count,
    output logic [NPOP*TAG_W-1:0]   head_tag,
    output logic [NPOP*PAY_W-1:0]   head_pay
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] tags;
        logic [DEPTH-1:0][PAY_W-1:0] pays;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (push) begin
                st_d.tags[st_q.wr] = push_tag;
                st_d.pays[st_q.wr] = push_pay;
                st_d.wr            = st_q.wr + PTR_W'(1);
            end
            st_d.rd  = st_q.rd + PTR_W'(pop_n);
            st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    for (genvar i = 0; i < NPOP; i++) begin : g_head
        logic [PTR_W-1:0] idx;
        assign idx = st_q.rd + PTR_W'(i);
        assign head_tag[i*TAG_W +: TAG_W] = st_q.tags[idx];
        assign head_pay[i*PAY_W +: PAY_W] = st_q.pays[idx];
    end
endmodule

// File: rtl/rlq_budget.sv
module rlq_budget #(
    parameter int unsigned BUD_W = 4,
    parameter int unsigned CNT_W = 5,
    parameter int unsigned NPOP  = 2,
    parameter int unsigned POPW  = $clog2(NPOP + 1)
) (
    input  logic [BUD_W-1:0] issue_width,
    input  logic [BUD_W-1:0] other_used,
    input  logic [CNT_W-1:0] count,
    input  logic             flush,
    output logic [POPW-1:0]  pop_n
);
    logic [BUD_W-1:0] room;
    logic [31:0]      n;

    always_comb begin
        room = (issue_width > other_used) ? (issue_width - other_used) : '0;
        n = 32'(NPOP);
        if (32'(room) < n)  n = 32'(room);
        if (32'(count) < n) n = 32'(count);
        if (flush)          n = '0;
        pop_n = POPW'(n);
    end
endmodule

// File: rtl/rlq_flags.sv
module rlq_flags #(
    parameter int unsigned TAG_W = 4,
    parameter int unsigned NT    = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_valid,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_valid,
    input  logic [TAG_W-1:0] clr_tag,
    output logic [NT-1:0]    delayed
);
    typedef struct packed {
        logic [NT-1:0] dly;
    } flags_t;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (flush) begin
            fl_d.dly = '0;
        end else begin
            if (clr_valid) fl_d.dly[clr_tag] = 1'b0;
            if (set_valid) fl_d.dly[set_tag] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign delayed = fl_q.dly;
endmodule

// File: rtl/load_replay_queue.sv
module load_replay_queue
    import rlq_pkg::*;
#(
    parameter int unsigned DEPTH = RLQ_DEPTH,
    parameter int unsigned TAG_W = RLQ_TAG_W,
    parameter int unsigned PAY_W = RLQ_PAY_W,
    parameter int unsigned BUD_W = RLQ_BUD_W,
    parameter int unsigned NPOP  = RLQ_NPOP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     defer_valid,
    input  logic [TAG_W-1:0]         defer_tag,
    input  logic [PAY_W-1:0]         defer_payload,
    input  logic [BUD_W-1:0]         issue_width,
    input  logic [BUD_W-1:0]         other_used,
    input  logic                     clr_valid,
    input  logic [TAG_W-1:0]         clr_tag,
    input  logic [(1<<TAG_W)-1:0]    scan_vec,
    output logic [NPOP-1:0]          replay_valid,
    output logic [NPOP*TAG_W-1:0]    replay_tag,
    output logic [NPOP*PAY_W-1:0]    replay_payload,
    output logic                     activity,
    output logic                     overflow,
    output logic [(1<<TAG_W)-1:0]    delayed_vec,
    output logic [(1<<TAG_W)-1:0]    violation_vec
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned POPW  = $clog2(NPOP + 1);
    localparam int unsigned NT    = 1 << TAG_W;

    logic [CNT_W-1:0] count;
    logic [POPW-1:0]  pop_n;
    logic             full;
    logic             accept;

    assign full     = (count == CNT_W'(DEPTH));
    assign overflow = defer_valid && full;
    assign accept   = defer_valid && !full && !flush;

    rlq_budget #(.BUD_W(BUD_W), .CNT_W(CNT_W), .NPOP(NPOP), .POPW(POPW)) u_budget (
        .issue_width (issue_width),
        .other_used  (other_used),
        .count       (count),
        .flush       (flush),
        .pop_n       (pop_n)
    );

    rlq_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PAY_W(PAY_W), .NPOP(NPOP),
                .CNT_W(CNT_W), .POPW(POPW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (accept),
        .push_tag (defer_tag),
        .push_pay (defer_payload),
        .pop_n    (pop_n),
        .count    (count),
        .head_tag (replay_tag),
        .head_pay (replay_payload)
    );

    rlq_flags #(.TAG_W(TAG_W), .NT(NT)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .set_valid (accept),
        .set_tag   (defer_tag),
        .clr_valid (clr_valid),
        .clr_tag   (clr_tag),
        .delayed   (delayed_vec)
    );

    for (genvar i = 0; i < NPOP; i++) begin : g_valid
        assign replay_valid[i] = (32'(pop_n) > 32'(i));
    end

    assign activity      = (count != '0) || (other_used != '0);
    assign violation_vec = scan_vec & ~delayed_vec;
endmodule

// File: rtl/rlq_checker.sv
module rlq_checker #(
    parameter int unsigned TAG_W = 4,
    parameter int unsigned BUD_W = 4,
    parameter int unsigned NPOP  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  flush,
    input logic                  defer_valid,
    input logic [TAG_W-1:0]      defer_tag,
    input logic [BUD_W-1:0]      issue_width,
    input logic [BUD_W-1:0]      other_used,
    input logic [NPOP-1:0]       replay_valid,
    input logic                  activity,
    input logic                  overflow,
    input logic [(1<<TAG_W)-1:0] delayed_vec,
    input logic [(1<<TAG_W)-1:0] violation_vec
);
    assert_low_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((replay_valid & (replay_valid + NPOP'(1))) == '0));

    assert_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_valid != '0) |-> ($countones(replay_valid) + int'(other_used) <= int'(issue_width)));

    assert_activity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid[0] |-> activity);

    assert_flush_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (replay_valid == '0));

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((delayed_vec == '0) && (activity == (other_used != '0))));

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (defer_valid && !overflow && !flush) |=> delayed_vec[$past(defer_tag)]);

    assert_masked_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((violation_vec & delayed_vec) == '0));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> defer_valid);
endmodule

bind load_replay_queue rlq_checker #(.TAG_W(TAG_W), .BUD_W(BUD_W), .NPOP(NPOP)) u_rlq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .defer_valid   (defer_valid),
    .defer_tag     (defer_tag),
    .issue_width   (issue_width),
    .other_used    (other_used),
    .replay_valid  (replay_valid),
    .activity      (activity),
    .overflow      (overflow),
    .delayed_vec   (delayed_vec),
    .violation_vec (violation_vec)
);

// File: tb/load_replay_queue_test.sv
`timescale 1ns/1ps
module load_replay_queue_test;
    localparam int DEPTH = 16;
    localparam int TW = 4;
    localparam int PW = 16;
    localparam int BW = 4;
    localparam int NP = 2;
    localparam int NT = 1 << TW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic defer_valid = 1'b0;
    logic [TW-1:0] defer_tag = '0;
    logic [PW-1:0] defer_payload = '0;
    logic [BW-1:0] issue_width = '0;
    logic [BW-1:0] other_used = '0;
    logic clr_valid = 1'b0;
    logic [TW-1:0] clr_tag = '0;
    logic [NT-1:0] scan_vec = '0;
    logic [NP-1:0] replay_valid;
    logic [NP*TW-1:0] replay_tag;
    logic [NP*PW-1:0] replay_payload;
    logic activity, overflow;
    logic [NT-1:0] delayed_vec, violation_vec;

    always #2.5 clk = ~clk;

    load_replay_queue uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .defer_valid(defer_valid),
        .defer_tag(defer_tag), .defer_payload(defer_payload),
        .issue_width(issue_width), .other_used(other_used),
        .clr_valid(clr_valid), .clr_tag(clr_tag), .scan_vec(scan_vec),
        .replay_valid(replay_valid), .replay_tag(replay_tag),
        .replay_payload(replay_payload), .activity(activity),
        .overflow(overflow), .delayed_vec(delayed_vec),
        .violation_vec(violation_vec)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    string note = "";
    int q_tag[$];
    int q_pay[$];
    logic [NT-1:0] m_dly = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, note, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // One cycle: drive at negedge, compare outputs to model, update model at posedge.
    task automatic step(input bit dv, input int dt, input int dp, input int iw, input int ou,
                        input bit fl, input bit cv, input int ct, input logic [NT-1:0] sv);
        int room, n;
        bit ovf;
        defer_valid = dv; defer_tag = TW'(dt); defer_payload = PW'(dp);
        issue_width = BW'(iw); other_used = BW'(ou); flush = fl;
        clr_valid = cv; clr_tag = TW'(ct); scan_vec = sv;
        #1;
        room = (iw > ou) ? iw - ou : 0;
        n = NP;
        if (room < n) n = room;
        if (q_tag.size() < n) n = q_tag.size();
        if (fl) n = 0;
        ovf = dv && (q_tag.size() == DEPTH);
        chk(fl ? "R6 replay_valid" : "R3 replay_valid", 64'(replay_valid), 64'((1 << n) - 1));
        for (int i = 0; i < n; i++) begin
            chk("R1 R2 replay_tag", 64'(replay_tag[i*TW +: TW]), 64'(q_tag[i]));
            chk("R11 replay_payload", 64'(replay_payload[i*PW +: PW]), 64'(q_pay[i]));
        end
        if (replay_valid != '0)
            chk("R4 budget", 64'($countones(replay_valid) + ou <= iw), 64'(1));
        chk("R5 activity", 64'(activity), 64'(q_tag.size() != 0 || ou != 0));
        chk("R9 overflow", 64'(overflow), 64'(ovf));
        chk("R7 delayed_vec", 64'(delayed_vec), 64'(m_dly));
        chk("R8 violation_vec", 64'(violation_vec), 64'(sv & ~m_dly));
        @(posedge clk);
        if (fl) begin
            q_tag.delete(); q_pay.delete(); m_dly = '0;
        end else begin
            for (int i = 0; i < n; i++) begin
                void'(q_tag.pop_front()); void'(q_pay.pop_front());
            end
            if (cv) m_dly[ct] = 1'b0;
            if (dv && !ovf) begin
                q_tag.push_back(dt); q_pay.push_back(dp); m_dly[dt] = 1'b1;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int iw, input int ou);
        step(0, 0, 0, iw, ou, 0, 0, 0, '0);
    endtask

    task automatic put(input int t, input int iw, input int ou);
        step(1, t, int'($urandom_range(0, 65535)), iw, ou, 0, 0, 0, '0);
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R3 reset replay_valid", 64'(replay_valid), 64'(0));
        chk("R5 reset activity", 64'(activity), 64'(0));
        chk("R7 reset delayed_vec", 64'(delayed_vec), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: park five loads with no budget
        note = "fill";
        for (int i = 0; i < 5; i++) put(i, 0, 0);
        // R3: budget below, above and beyond other_used
        note = "budget";
        idle(4, 3);
        idle(4, 5);
        idle(4, 4);
        idle(9, 0);
        // R10: defer with one replay
        note = "R10 push-pop";
        step(1, 7, 16'hBEEF, 3, 2, 0, 0, 0, '0);
        // drain, then activity from other_used only (R5)
        note = "drain";
        for (int i = 0; i < 4; i++) idle(2, 0);
        idle(0, 1);
        idle(0, 0);

        // R9 and R10: fill to DEPTH-1, push+pop, then reach DEPTH and overflow
        note = "R10 full";
        for (int i = 0; i < DEPTH - 1; i++) put(i, 0, 0);
        step(1, 9, 16'h1234, 1, 0, 0, 0, 0, '0);
        put(10, 0, 0);
        put(11, 0, 0);
        note = "R9 overflow with pop";
        put(12, 2, 0);
        idle(0, 0);

        // R7 clears, R8 scan masking
        note = "flags";
        step(0, 0, 0, 0, 0, 0, 1, 3, 16'hFFFF);
        step(0, 0, 0, 0, 0, 0, 1, 3, 16'hFFFF);
        step(1, 5, 16'h0505, 0, 0, 0, 1, 5, 16'hFFFF);
        step(0, 0, 0, 0, 0, 0, 1, 15, 16'hA5A5);

        // R6 flush with content, defer and budget
        note = "R6 flush";
        step(1, 2, 16'h2222, 4, 0, 1, 0, 0, 16'hFFFF);
        idle(4, 0);
        put(6, 0, 0);
        idle(4, 0);

        // random phase
        note = "random";
        for (int k = 0; k < 400; k++) begin
            step(bit'($urandom_range(0, 99) < 60), int'($urandom_range(0, NT - 1)),
                 int'($urandom_range(0, 65535)), int'($urandom_range(0, 6)),
                 int'($urandom_range(0, 4)), bit'($urandom_range(0, 99) < 3),
                 bit'($urandom_range(0, 99) < 25), int'($urandom_range(0, NT - 1)),
                 NT'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule